// File: doc/BRIEF.md
# Recursive Optical-Black Line Clamp

This block sits in an image-sensor pixel path and removes the black offset from each raster line. Pixels arrive 10 bits wide. A line-valid strobe frames each line, and a pixel-valid strobe marks each cycle that carries a pixel. A configurable window of 16 consecutive pixels on every line lies in the sensor's shielded (optical-black) area. The block sums those 16 samples and divides the sum by 16 to get the line's black estimate.

The estimate is not used on its own. It is blended with the level held from earlier lines in a first-order recursive filter, weighted by a 4-bit coefficient k. Every pixel after the window has the rounded filtered level subtracted from it, with the result floored at zero. The black level of the output is therefore uniform from line to line. The blend is held in fixed point with four fractional bits, so small line-to-line changes are not lost in truncation. A frame-start pulse reseeds the filter from the next complete window.

The output keeps the input framing. It carries the same strobes delayed by a fixed two clocks, and pixels that are not clamped leave unchanged.

Top module: `ob_clamp`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is active, out_line_valid, out_pix_valid and out_data are all zero. The filter level is cleared and the filter is marked unseeded.
- R2: out_line_valid and out_pix_valid equal line_valid and pix_valid from exactly two clocks earlier. A pixel accepted at one edge appears on out_data after the following edge.
- R3: Pixel position counts the cycles with line_valid and pix_valid both high. It restarts at 0 whenever line_valid is low. Positions below win_start (leading) and positions win_start to win_start+15 (black window) are output unchanged.
- R4: The line's black average is floor(S/16), where S is the sum of the 16 window pixels, held in a 14-bit accumulator. With k = 0 the clamp level equals this average exactly.
- R5: The first complete window after reset or after a frame_start pulse seeds the level. The level, in sixteenths, becomes 16·avg, and k is ignored for that line.
- R6: Every later complete window updates the level L (in sixteenths, 14 bits) to (k·L + (16−k)·16·avg + 8) >> 4, with k read from k_coef as an unsigned count of sixteenths (0..15).
- R7: The clamp value is C = min((L + 8) >> 4, 1023). Each pixel after the window is output as max(pixel − C, 0).
- R8: A level update from a line's window takes effect from the first pixel that follows that window on the same line.
- R9: A line that ends before its window completes leaves the level and the seeded state unchanged.
- R10: Cycles inside a line with pix_valid low do not advance the position and do not touch the accumulator, including gaps inside the black window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that marks the filter unseeded |
| line_valid | input | 1 | High for the duration of a raster line |
| pix_valid | input | 1 | High on cycles carrying a pixel |
| pix_data | input | 10 | Input pixel value |
| win_start | input | 12 | Position of the first black-window pixel in the line |
| k_coef | input | 4 | Recursive weight of the previous level, in sixteenths |
| out_line_valid | output | 1 | line_valid delayed two clocks |
| out_pix_valid | output | 1 | pix_valid delayed two clocks |
| out_data | output | 10 | Clamped or passed-through pixel |

## Verification
The hardest state to reach from the ports is a filter level that reflects a particular history. It depends on whether the window completed, whether a reseed was pending, and on the pixel-valid gaps that fell inside the window. None of this is visible except through later subtracted pixels. The stimulus mixes directed lines with random ones. The directed lines are a seeding line, a k = 0 line, a k = 15 line, a window at position zero, a line cut short inside its window followed by a heavily weighted line, and a mid-stream frame-start. The random lines draw the coefficient, window position, black range and gap density from a fixed seed. A bench model rebuilds the level from the same rules, so each clamped pixel shows whether the level history is correct.

// File: rtl/ob_clamp_pkg.sv
// Shared types for the optical-black line clamp.
package ob_clamp_pkg;
    // Classification of the current input cycle within a line.
    typedef enum logic [1:0] {
        PX_NONE   = 2'd0,
        PX_LEAD   = 2'd1,
        PX_BLACK  = 2'd2,
        PX_ACTIVE = 2'd3
    } px_class_e;
endpackage

// File: rtl/ob_pos_tracker.sv
// Pixel position tracker.
// Counts accepted pixels (line_valid & pix_valid) within a line and sorts the
// current cycle into leading, black-window or active. Assumes win_start is
// held stable while a line is in progress. The count saturates at its maximum.
module ob_pos_tracker
    import ob_clamp_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int BLK_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_valid,
    input  logic             pix_valid,
    input  logic [IDX_W-1:0] win_start,
    output px_class_e        px_class,
    output logic             last_black
);
    localparam logic [IDX_W:0]   BLK_N   = (IDX_W+1)'(2**BLK_LOG2);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   idx_x;
    logic [IDX_W:0]   win_end;

    assign idx_x   = {1'b0, idx};
    assign win_end = {1'b0, win_start} + BLK_N;

    // Position counter: cleared between lines, advanced per accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || !line_valid) begin
            idx <= '0;
        end else if (pix_valid && idx != IDX_MAX) begin
            idx <= idx + 1'b1;
        end
    end

    // Classify the current cycle against the black window.
    always_comb begin
        px_class   = PX_NONE;
        last_black = 1'b0;
        if (line_valid && pix_valid) begin
            if (idx < win_start) begin
                px_class = PX_LEAD;
            end else if (idx_x < win_end) begin
                px_class   = PX_BLACK;
                last_black = (idx_x == win_end - 1'b1);
            end else begin
                px_class = PX_ACTIVE;
            end
        end
    end

    AST_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |=> idx == '0);                                  // R3
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !pix_valid) |=> $stable(idx));                // R10
endmodule

// File: rtl/ob_black_accum.sv
// Black-window accumulator.
// Sums window pixels of the current line. On the last window pixel it presents
// the full sum divided by the window size (a right shift). Assumes the window
// holds exactly 2**BLK_LOG2 pixels, so the sum fits DATA_W+BLK_LOG2 bits.
module ob_black_accum #(
    parameter int DATA_W   = 10,
    parameter int BLK_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_valid,
    input  logic              take,
    input  logic              last,
    input  logic [DATA_W-1:0] pix,
    output logic [DATA_W-1:0] avg
);
    localparam int          ACC_W    = DATA_W + BLK_LOG2;
    localparam logic [ACC_W-1:0] ACC_PART =
        ACC_W'((2**DATA_W - 1) * (2**BLK_LOG2 - 1));

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_nxt;

    assign sum_nxt = acc + ACC_W'(pix);
    assign avg     = sum_nxt[ACC_W-1:BLK_LOG2];

    // Accumulate window pixels; restart on line gaps and after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || !line_valid) begin
            acc <= '0;
        end else if (take) begin
            acc <= last ? '0 : sum_nxt;
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_PART);                                            // R4
endmodule

// File: rtl/ob_level_filter.sv
// Recursive black-level filter.
// Holds the level with FR_W fractional bits. It is seeded from the first
// average after reset or frame_start, then blended as
// k*L + (ONE-k)*avg with rounding. Outputs the level rounded to whole codes
// and saturated. Assumes k is a fraction of 2**K_W.
module ob_level_filter #(
    parameter int DATA_W = 10,
    parameter int K_W    = 4,
    parameter int FR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              upd,
    input  logic [DATA_W-1:0] avg,
    input  logic [K_W-1:0]    k,
    output logic [DATA_W-1:0] clamp_lvl
);
    localparam int LQ_W = DATA_W + FR_W;
    localparam int PR_W = LQ_W + K_W + 1;
    localparam logic [PR_W-1:0] ONE_K  = PR_W'(2**K_W);
    localparam logic [PR_W-1:0] HALF_K = PR_W'(2**(K_W-1));
    localparam logic [LQ_W:0]   HALF_F = (LQ_W+1)'(2**(FR_W-1));
    localparam logic [LQ_W-1:0] LQ_MAX = LQ_W'((2**DATA_W - 1) * (2**FR_W));

    logic [LQ_W-1:0]   lvl_q;
    logic              seeded;
    logic [LQ_W-1:0]   avg_q;
    logic [PR_W-1:0]   k_x;
    logic [PR_W-1:0]   prod;
    logic [LQ_W-1:0]   blend;
    logic [LQ_W:0]     rnd;
    logic [DATA_W:0]   clamp_raw;

    assign avg_q = {avg, {FR_W{1'b0}}};
    assign k_x   = PR_W'(k);

    // Weighted sum of the held level and the new average, rounded back.
    always_comb begin
        prod  = k_x * PR_W'(lvl_q) + (ONE_K - k_x) * PR_W'(avg_q) + HALF_K;
        blend = LQ_W'(prod >> K_W);
    end

    // Level and seed state update; frame_start wins over a same-cycle seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            seeded <= 1'b0;
        end else begin
            if (upd) begin
                lvl_q  <= seeded ? blend : avg_q;
                seeded <= 1'b1;
            end
            if (frame_start) begin
                seeded <= 1'b0;
            end
        end
    end

    // Round the fractional level to whole codes and saturate.
    always_comb begin
        rnd       = {1'b0, lvl_q} + HALF_F;
        clamp_raw = rnd[LQ_W:FR_W];
        clamp_lvl = clamp_raw[DATA_W] ? '1 : clamp_raw[DATA_W-1:0];
    end

    AST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !seeded) |=> lvl_q == {$past(avg), {FR_W{1'b0}}});   // R5
    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(lvl_q));                                    // R9
    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= LQ_MAX);                                            // R6
endmodule

// File: rtl/ob_out_stage.sv
// Two-stage output pipeline.
// Stage 1 registers the pixel and its class. Stage 2 subtracts the clamp
// level from active pixels with a floor at zero and passes the rest unchanged.
// The clamp level is read when stage 2 loads, so an update made on the last
// window pixel already reaches the next pixel.
module ob_out_stage
    import ob_clamp_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_valid,
    input  logic              pix_valid,
    input  px_class_e         px_class,
    input  logic [DATA_W-1:0] pix,
    input  logic [DATA_W-1:0] clamp_lvl,
    output logic              out_lv,
    output logic              out_pv,
    output logic [DATA_W-1:0] out_data
);
    logic              s1_lv;
    logic              s1_pv;
    logic              s1_act;
    logic [DATA_W-1:0] s1_d;
    logic [DATA_W:0]   diff;

    assign diff = {1'b0, s1_d} - {1'b0, clamp_lvl};

    // Stage 1: capture strobes, pixel and whether it is to be clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_lv  <= 1'b0;
            s1_pv  <= 1'b0;
            s1_act <= 1'b0;
            s1_d   <= '0;
        end else begin
            s1_lv  <= line_valid;
            s1_pv  <= pix_valid;
            s1_act <= (px_class == PX_ACTIVE);
            s1_d   <= pix;
        end
    end

    // Stage 2: subtract with floor at zero, or pass through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lv   <= 1'b0;
            out_pv   <= 1'b0;
            out_data <= '0;
        end else begin
            out_lv   <= s1_lv;
            out_pv   <= s1_pv;
            if (s1_act) begin
                out_data <= diff[DATA_W] ? '0 : diff[DATA_W-1:0];
            end else begin
                out_data <= s1_d;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_pv && s1_act) |=> out_data <= $past(s1_d));              // R7
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_pv && !s1_act) |=> out_data == $past(s1_d));             // R3
endmodule

// File: rtl/ob_clamp.sv
// Optical-black line clamp, top level.
// Ties the position tracker, window accumulator, recursive level filter and
// output pipeline together. Assumes win_start and k_coef are stable within
// a line and frame_start is pulsed between lines.
module ob_clamp
    import ob_clamp_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int IDX_W    = 12,
    parameter int K_W      = 4,
    parameter int BLK_LOG2 = 4,
    parameter int FR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_valid,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    input  logic [IDX_W-1:0]  win_start,
    input  logic [K_W-1:0]    k_coef,
    output logic              out_line_valid,
    output logic              out_pix_valid,
    output logic [DATA_W-1:0] out_data
);
    px_class_e         px_class;
    logic              last_black;
    logic              take;
    logic [DATA_W-1:0] avg;
    logic [DATA_W-1:0] clamp_lvl;
    logic [1:0]        age;

    assign take = (px_class == PX_BLACK);

    ob_pos_tracker #(.IDX_W(IDX_W), .BLK_LOG2(BLK_LOG2)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (line_valid),
        .pix_valid  (pix_valid),
        .win_start  (win_start),
        .px_class   (px_class),
        .last_black (last_black)
    );

    ob_black_accum #(.DATA_W(DATA_W), .BLK_LOG2(BLK_LOG2)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (line_valid),
        .take       (take),
        .last       (last_black),
        .pix        (pix_data),
        .avg        (avg)
    );

    ob_level_filter #(.DATA_W(DATA_W), .K_W(K_W), .FR_W(FR_W)) u_flt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .upd         (last_black),
        .avg         (avg),
        .k           (k_coef),
        .clamp_lvl   (clamp_lvl)
    );

    ob_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (line_valid),
        .pix_valid  (pix_valid),
        .px_class   (px_class),
        .pix        (pix_data),
        .clamp_lvl  (clamp_lvl),
        .out_lv     (out_line_valid),
        .out_pv     (out_pix_valid),
        .out_data   (out_data)
    );

    // Cycles since reset, saturating at two, to gate the depth-2 checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    AST_LV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> out_line_valid == $past(line_valid, 2));    // R2
    AST_PV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> out_pix_valid == $past(pix_valid, 2));      // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_line_valid && !out_pix_valid && out_data == '0)); // R1
endmodule

// File: tb/sim_ob_clamp.sv
module sim_ob_clamp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       line_valid = 1'b0;
    logic       pix_valid = 1'b0;
    logic [9:0] pix_data = '0;
    logic [11:0] win_start = '0;
    logic [3:0] k_coef = '0;
    logic       out_line_valid;
    logic       out_pix_valid;
    logic [9:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int    exp_d[$];
    string exp_tag[$];

    // Bench model of the filter state
    int m_lvl = 0;
    bit m_seeded = 1'b0;

    // Two-deep history of input strobes for the latency check
    logic d1_lv = 1'b0, d2_lv = 1'b0, d1_pv = 1'b0, d2_pv = 1'b0;

    always #2 clk = ~clk;

    ob_clamp u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_valid(line_valid), .pix_valid(pix_valid), .pix_data(pix_data),
        .win_start(win_start), .k_coef(k_coef),
        .out_line_valid(out_line_valid), .out_pix_valid(out_pix_valid),
        .out_data(out_data)
    );

    function automatic int blend_f(int kk, int prev, int avg);
        return (kk * prev + (16 - kk) * avg * 16 + 8) >> 4;
    endfunction

    function automatic int clamp_f(int lvl);
        int c = (lvl + 8) >> 4;
        return (c > 1023) ? 1023 : c;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 line_valid delay", int'(out_line_valid), int'(d2_lv));
            check("R2 pix_valid delay", int'(out_pix_valid), int'(d2_pv));
            if (out_pix_valid) begin
                if (exp_d.size() == 0) begin
                    check("R2 unexpected pixel", 1, 0);
                end else begin
                    check(exp_tag.pop_front(), int'(out_data), exp_d.pop_front());
                end
            end
        end
        d2_lv = d1_lv; d1_lv = line_valid;
        d2_pv = d1_pv; d1_pv = pix_valid;
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            line_valid = 1'b0; pix_valid = 1'b0; frame_start = 1'b0;
        end
    endtask

    task automatic frame_pulse();
        @(posedge clk); #1;
        line_valid = 1'b0; pix_valid = 1'b0; frame_start = 1'b1;
        m_seeded = 1'b0;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    // One line: len pixels, window at start, black values in [blo,bhi]
    task automatic drive_line(int len, int start, int kk, int gap_pct,
                              int blo, int bhi, string tag);
        int sum = 0;
        bit first_act = 1'b1;
        win_start = 12'(start);
        k_coef = 4'(kk);
        for (int i = 0; i < len; i++) begin
            int v;
            int e;
            while (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
                @(posedge clk); #1;
                line_valid = 1'b1; pix_valid = 1'b0;
                pix_data = 10'($urandom);
            end
            if (i >= start && i < start + 16) begin
                v = blo + int'($urandom % 32'(bhi - blo + 1));
                sum += v;
                e = v;
                exp_tag.push_back("R3 black pixel unchanged");
                if (i == start + 15) begin
                    int avg = sum >> 4;
                    if (!m_seeded) begin
                        m_lvl = avg * 16;
                        m_seeded = 1'b1;
                    end else begin
                        m_lvl = blend_f(kk, m_lvl, avg);
                    end
                end
            end else if (i < start) begin
                v = int'($urandom % 1024);
                e = v;
                exp_tag.push_back("R3 leading pixel unchanged");
            end else begin
                v = int'($urandom % 1024);
                e = v - clamp_f(m_lvl);
                if (e < 0) e = 0;
                exp_tag.push_back(first_act ? {tag, " R8 first active"} : {tag, " R7 active"});
                first_act = 1'b0;
            end
            exp_d.push_back(e);
            @(posedge clk); #1;
            line_valid = 1'b1; pix_valid = 1'b1; pix_data = 10'(v);
        end
        @(posedge clk); #1;
        line_valid = 1'b0; pix_valid = 1'b0;
        idle(3);
    endtask

    initial begin
        void'($urandom(32'd7));
        // R1: outputs quiet during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 reset out_line_valid", int'(out_line_valid), 0);
            check("R1 reset out_pix_valid", int'(out_pix_valid), 0);
            check("R1 reset out_data", int'(out_data), 0);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        frame_pulse();
        drive_line(60, 4, 8, 0, 50, 70, "R5 seed");
        drive_line(50, 6, 0, 0, 80, 120, "R4 k=0");
        drive_line(50, 2, 15, 0, 10, 30, "R6 k=15");
        drive_line(40, 0, 5, 0, 60, 64, "R8 window at 0");
        // R9: line cut inside the window, then heavily weighted line
        drive_line(14, 4, 3, 0, 900, 1000, "R9 short");
        drive_line(50, 3, 15, 0, 0, 5, "R9 level kept");
        // R10: gaps inside the window and actives
        drive_line(60, 8, 9, 35, 40, 90, "R10 gaps");
        drive_line(60, 1, 12, 20, 200, 260, "R10 gaps");
        // R5: reseed mid-stream
        frame_pulse();
        drive_line(50, 5, 15, 0, 300, 340, "R5 reseed");
        drive_line(50, 5, 7, 0, 900, 1023, "R7 floor");
        for (int n = 0; n < 30; n++) begin
            int len = 30 + int'($urandom % 60);
            int st  = int'($urandom % 20);
            int lo  = int'($urandom % 600);
            int gp  = (n % 3 == 0) ? 25 : 0;
            if (n == 15) frame_pulse();
            drive_line(len, st, int'($urandom % 16), gp, lo, lo + int'($urandom % 300),
                       "R6 random");
        end
        idle(6);
        check("R2 all pixels emitted", exp_d.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule